// File: doc/BRIEF.md
# Cartridge Read-Port to 8-Bit I/O Bus Bridge

This block lets a host reach an ISA-style I/O peripheral through a cartridge port that can only issue read cycles. The host encodes everything in the address. A field of upper address bits picks one of 32 peripheral registers. One address bit chooses the direction: the lower window produces a peripheral read and the upper window produces a peripheral write. For a write, the byte to send sits on a field of low address bits. Each host access becomes one complete peripheral cycle. The address is set up first, then one active-low strobe is driven for a fixed number of clocks, then the address is held.

A mode input selects how wide the data path is. In byte mode, read data comes back on the upper half of the host data bus and write data is a single byte. In wide mode, a read returns all 16 peripheral data bits. The same read also loads its low address byte into a holding latch. The next write-window access then sends a 16-bit word, with its own address byte as the high half and the latched byte as the low half. This is how a full word is written over a bus that has no write cycle.

The host keeps `host_cs` high and `host_addr` steady until it sees `host_ack`. It must drop `host_cs` before it starts another access.

Top module: `isa_cart_bridge`

## Requirements
- R1: While a strobe is low, `isa_addr` equals 0x300 plus the 5-bit register field `host_addr[13:9]`.
- R2: `host_addr[16]` = 0 produces a read strobe on `isa_ior_n` only. `host_addr[16]` = 1 produces a write strobe on `isa_iow_n` only.
- R3: In byte mode (`mode_wide`=0), a write drives `isa_dout` = {8'h00, `host_addr[8:1]`}.
- R4: In byte mode, a read returns {`isa_din[7:0]`, 8'h00} on `host_data` together with `host_ack`.
- R5: In wide mode (`mode_wide`=1), a read returns `isa_din[15:0]` on `host_data`.
- R6: In wide mode, a read loads `host_addr[8:1]` into the holding latch. A wide-mode write drives `isa_dout` = {`host_addr[8:1]`, latch}.
- R7: A byte-mode read never changes the holding latch.
- R8: Each access gives exactly one strobe pulse, low for STROBE_CYC clocks (default 2). `isa_addr` is stable in the clock before the strobe falls and in the clock after it rises.
- R9: No strobe is low while `host_cs` is low. Dropping `host_cs` mid-access releases the strobe at once, and no `host_ack` follows.
- R10: Reset (`rst_n` low, synchronous) leaves both strobes high, `host_ack` low and the holding latch at zero.
- R11: `host_data_oe` is high only during the completion of a read-window access. It stays low for write-window accesses.
- R12: `host_ack` is a single-clock pulse. Holding `host_cs` high after it starts no further access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_wide | input | 1 | 0 = byte mode, 1 = 16-bit split-write mode |
| host_cs | input | 1 | Host access select, held until acknowledged |
| host_addr | input | 24 | Host address: window bit, register field, byte field |
| host_data | output | 16 | Read data returned to the host |
| host_data_oe | output | 1 | Host data bus drive enable |
| host_ack | output | 1 | One-clock completion pulse |
| isa_addr | output | 10 | Peripheral I/O address |
| isa_dout | output | 16 | Peripheral write data |
| isa_din | input | 16 | Peripheral read data |
| isa_ior_n | output | 1 | Active-low read strobe |
| isa_iow_n | output | 1 | Active-low write strobe |

## Verification
The only hidden state is the holding latch, and it cannot be read directly. A fault in it shows up at the ports on the next wide-mode write, as a wrong low byte on `isa_dout`. The vector order therefore interleaves latch loads, byte-mode reads that must leave the latch alone, and wide writes that expose it.

A wrong sequencer state shows within a few clocks in other ways:
- as a missing or doubled strobe pulse;
- as a pulse of the wrong length;
- as an acknowledge that never arrives.

Aborts, repeated selects and reset are each checked directly at the strobes and at the first write that follows.

// File: rtl/isa_br_pkg.sv
// Shared types for the cartridge-to-I/O bridge.
package isa_br_pkg;
    // Phases of one peripheral access.
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_STROBE,
        ST_HOLD,
        ST_DONE,
        ST_WAIT
    } seq_st_t;
endpackage

// File: rtl/isa_br_decode.sv
// Address decoder: splits the host address into direction, peripheral
// register address and data byte. Purely combinational.
// Assumes the fields do not overlap and lie within HOST_AW.
module isa_br_decode #(
    parameter int HOST_AW  = 24,
    parameter int WIN_BIT  = 16,
    parameter int REG_LSB  = 9,
    parameter int REG_W    = 5,
    parameter int BYTE_LSB = 1,
    parameter int ISA_AW   = 10,
    parameter logic [ISA_AW-1:0] ISA_BASE = 10'h300
) (
    input  logic [HOST_AW-1:0] addr_i,
    output logic               is_wr_o,
    output logic [ISA_AW-1:0]  isa_addr_o,
    output logic [7:0]         byte_o
);
    // Field extraction and base offset.
    always_comb begin
        is_wr_o    = addr_i[WIN_BIT];
        isa_addr_o = ISA_BASE | ISA_AW'(addr_i[REG_LSB +: REG_W]);
        byte_o     = addr_i[BYTE_LSB +: 8];
    end
endmodule

// File: rtl/isa_br_wlatch.sv
// Holding latch for the low byte of a split 16-bit write.
// Assumes load is a single-clock pulse. Cleared by reset.
module isa_br_wlatch #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    // Capture the byte on load, clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)      q_o <= '0;
        else if (load_i) q_o <= d_i;
    end
endmodule

// File: rtl/isa_br_seq.sv
// Access sequencer: setup clock, STROBE_CYC strobe clocks, hold clock,
// one-clock completion, then wait for the select to drop.
// Losing the select in any phase returns to idle without completing.
module isa_br_seq
    import isa_br_pkg::*;
#(
    parameter int STROBE_CYC = 2,
    localparam int CW = (STROBE_CYC > 1) ? $clog2(STROBE_CYC) : 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_i,
    output logic launch_o,
    output logic strobe_o,
    output logic cap_o,
    output logic done_o,
    output logic result_o
);
    seq_st_t       st;
    logic [CW-1:0] cnt;
    logic          last_strobe;

    // Decode phase outputs from the state.
    always_comb begin
        last_strobe = (cnt == CW'(STROBE_CYC - 1));
        launch_o    = (st == ST_IDLE) && cs_i;
        strobe_o    = (st == ST_STROBE);
        cap_o       = (st == ST_STROBE) && last_strobe && cs_i;
        done_o      = (st == ST_DONE);
        result_o    = (st == ST_DONE) || (st == ST_WAIT);
    end

    // Advance through the phases of one access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st  <= ST_IDLE;
            cnt <= '0;
        end else if (!cs_i) begin
            st  <= ST_IDLE;
            cnt <= '0;
        end else begin
            unique case (st)
                ST_IDLE:   st <= ST_SETUP;
                ST_SETUP:  begin st <= ST_STROBE; cnt <= '0; end
                ST_STROBE: begin
                    if (last_strobe) st <= ST_HOLD;
                    else             cnt <= cnt + 1'b1;
                end
                ST_HOLD:   st <= ST_DONE;
                ST_DONE:   st <= ST_WAIT;
                ST_WAIT:   st <= ST_WAIT;
                default:   st <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/isa_cart_bridge.sv
// Top: bridges read-only host cycles to peripheral reads and writes.
// Assumes the host holds host_addr and mode_wide steady while host_cs
// is high, and drops host_cs between accesses.
module isa_cart_bridge #(
    parameter int HOST_AW    = 24,
    parameter int WIN_BIT    = 16,
    parameter int REG_LSB    = 9,
    parameter int REG_W      = 5,
    parameter int BYTE_LSB   = 1,
    parameter int ISA_AW     = 10,
    parameter logic [ISA_AW-1:0] ISA_BASE = 10'h300,
    parameter int STROBE_CYC = 2,
    localparam int DW = 16,
    localparam int BW = DW / 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               mode_wide,
    input  logic               host_cs,
    input  logic [HOST_AW-1:0] host_addr,
    output logic [DW-1:0]      host_data,
    output logic               host_data_oe,
    output logic               host_ack,
    output logic [ISA_AW-1:0]  isa_addr,
    output logic [DW-1:0]      isa_dout,
    input  logic [DW-1:0]      isa_din,
    output logic               isa_ior_n,
    output logic               isa_iow_n
);
    logic              dec_wr;
    logic [ISA_AW-1:0] dec_addr;
    logic [BW-1:0]     dec_byte;
    logic [BW-1:0]     latch_q;
    logic              launch, strobe, cap, done, result;
    logic              wr_q, wide_q;
    logic [DW-1:0]     rd_q;

    isa_br_decode #(
        .HOST_AW(HOST_AW), .WIN_BIT(WIN_BIT), .REG_LSB(REG_LSB),
        .REG_W(REG_W), .BYTE_LSB(BYTE_LSB), .ISA_AW(ISA_AW),
        .ISA_BASE(ISA_BASE)
    ) u_dec (
        .addr_i(host_addr), .is_wr_o(dec_wr),
        .isa_addr_o(dec_addr), .byte_o(dec_byte)
    );

    isa_br_wlatch #(.W(BW)) u_latch (
        .clk(clk), .rst_n(rst_n),
        .load_i(launch && mode_wide && !dec_wr),
        .d_i(dec_byte), .q_o(latch_q)
    );

    isa_br_seq #(.STROBE_CYC(STROBE_CYC)) u_seq (
        .clk(clk), .rst_n(rst_n), .cs_i(host_cs),
        .launch_o(launch), .strobe_o(strobe), .cap_o(cap),
        .done_o(done), .result_o(result)
    );

    // Register the access parameters when an access starts.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            isa_addr <= ISA_BASE;
            isa_dout <= '0;
            wr_q     <= 1'b0;
            wide_q   <= 1'b0;
        end else if (launch) begin
            isa_addr <= dec_addr;
            wr_q     <= dec_wr;
            wide_q   <= mode_wide;
            if (dec_wr) isa_dout <= mode_wide ? {dec_byte, latch_q}
                                              : {{BW{1'b0}}, dec_byte};
        end
    end

    // Capture peripheral read data at the last strobe clock.
    always_ff @(posedge clk) begin
        if (!rst_n)              rd_q <= '0;
        else if (cap && !wr_q)   rd_q <= wide_q ? isa_din
                                                : {isa_din[BW-1:0], {BW{1'b0}}};
    end

    // Strobes gated by the select; host bus driven only on read results.
    always_comb begin
        isa_ior_n    = !(strobe && host_cs && !wr_q);
        isa_iow_n    = !(strobe && host_cs && wr_q);
        host_ack     = done;
        host_data_oe = result && host_cs && !wr_q;
        host_data    = host_data_oe ? rd_q : '0;
    end
endmodule

// File: rtl/isa_cart_bridge_chk.sv
// Property checker for isa_cart_bridge, attached by bind below.
module isa_cart_bridge_chk #(
    parameter int HOST_AW = 24,
    parameter int WIN_BIT = 16,
    parameter int REG_LSB = 9,
    parameter int REG_W   = 5,
    parameter int ISA_AW  = 10,
    parameter logic [ISA_AW-1:0] ISA_BASE = 10'h300
) (
    input logic               clk,
    input logic               rst_n,
    input logic               host_cs,
    input logic [HOST_AW-1:0] host_addr,
    input logic               host_ack,
    input logic               host_data_oe,
    input logic [ISA_AW-1:0]  isa_addr,
    input logic               isa_ior_n,
    input logic               isa_iow_n
);
    a_r9_no_strobe_without_cs: assert property (@(posedge clk) disable iff (!rst_n)
        !host_cs |-> (isa_ior_n && isa_iow_n));
    a_r2_one_strobe_kind: assert property (@(posedge clk) disable iff (!rst_n)
        !(!isa_ior_n && !isa_iow_n));
    a_r2_read_window: assert property (@(posedge clk) disable iff (!rst_n)
        !isa_ior_n |-> !host_addr[WIN_BIT]);
    a_r2_write_window: assert property (@(posedge clk) disable iff (!rst_n)
        !isa_iow_n |-> host_addr[WIN_BIT]);
    a_r1_addr_map: assert property (@(posedge clk) disable iff (!rst_n)
        (!isa_ior_n || !isa_iow_n) |->
            (isa_addr == (ISA_BASE | ISA_AW'(host_addr[REG_LSB +: REG_W]))));
    a_r8_addr_setup: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(isa_ior_n) || $fell(isa_iow_n)) |-> $stable(isa_addr));
    a_r8_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(isa_ior_n) || $rose(isa_iow_n)) |=> $stable(isa_addr));
    a_r11_oe_read_only: assert property (@(posedge clk) disable iff (!rst_n)
        host_data_oe |-> (host_cs && !host_addr[WIN_BIT]));
    a_r12_ack_single: assert property (@(posedge clk) disable iff (!rst_n)
        host_ack |=> !host_ack);
endmodule

bind isa_cart_bridge isa_cart_bridge_chk #(
    .HOST_AW(HOST_AW), .WIN_BIT(WIN_BIT), .REG_LSB(REG_LSB),
    .REG_W(REG_W), .ISA_AW(ISA_AW), .ISA_BASE(ISA_BASE)
) u_chk (
    .clk(clk), .rst_n(rst_n), .host_cs(host_cs), .host_addr(host_addr),
    .host_ack(host_ack), .host_data_oe(host_data_oe), .isa_addr(isa_addr),
    .isa_ior_n(isa_ior_n), .isa_iow_n(isa_iow_n)
);

// File: tb/tb_isa_cart_bridge.sv
module tb_isa_cart_bridge;
    localparam int STROBE_CYC = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mode_wide = 1'b0;
    logic        host_cs = 1'b0;
    logic [23:0] host_addr = '0;
    logic [15:0] host_data;
    logic        host_data_oe, host_ack;
    logic [9:0]  isa_addr;
    logic [15:0] isa_dout;
    logic [15:0] isa_din = '0;
    logic        isa_ior_n, isa_iow_n;

    isa_cart_bridge #(.STROBE_CYC(STROBE_CYC)) dut (
        .clk(clk), .rst_n(rst_n), .mode_wide(mode_wide), .host_cs(host_cs),
        .host_addr(host_addr), .host_data(host_data),
        .host_data_oe(host_data_oe), .host_ack(host_ack),
        .isa_addr(isa_addr), .isa_dout(isa_dout), .isa_din(isa_din),
        .isa_ior_n(isa_ior_n), .isa_iow_n(isa_iow_n)
    );

    always #10 clk = ~clk;

    int tests = 0, fails = 0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Strobe monitor, sampled mid-low-phase of the clock.
    int ior_pulses = 0, iow_pulses = 0, cur_len = 0, last_len = 0;
    logic [9:0]  snap_addr;
    logic [15:0] snap_dout;
    logic prev_ior = 1'b1, prev_iow = 1'b1;
    always @(negedge clk) begin
        #2;
        if (prev_ior && !isa_ior_n) begin ior_pulses++; cur_len = 0; end
        if (prev_iow && !isa_iow_n) begin iow_pulses++; cur_len = 0; end
        if (!isa_ior_n || !isa_iow_n) begin
            cur_len++; snap_addr = isa_addr; snap_dout = isa_dout;
        end
        if ((!prev_ior && isa_ior_n) || (!prev_iow && isa_iow_n)) last_len = cur_len;
        prev_ior = isa_ior_n;
        prev_iow = isa_iow_n;
    end

    function automatic logic [23:0] mk(input bit win, input logic [4:0] rg, input logic [7:0] bt);
        return {7'd0, win, 2'b00, rg, bt, 1'b0};
    endfunction

    bit got_ack, got_oe;
    logic [15:0] got_data;

    task automatic access(input bit w, input bit win, input logic [4:0] rg,
                          input logic [7:0] bt, input logic [15:0] din);
        @(negedge clk);
        mode_wide = w; isa_din = din; host_addr = mk(win, rg, bt); host_cs = 1'b1;
        got_ack = 0; got_oe = 0; got_data = '0;
        for (int i = 0; i < 30 && !got_ack; i++) begin
            @(negedge clk); #4;
            if (host_ack) begin got_ack = 1; got_data = host_data; got_oe = host_data_oe; end
        end
        host_cs = 1'b0;
        @(negedge clk); #4;
    endtask

    typedef struct packed {
        logic       wide;
        logic       win;
        logic [4:0] rg;
        logic [7:0] bt;
        logic [15:0] din;
        logic [15:0] exp;
    } vec_t;

    // exp: host_data for reads, isa_dout for writes.
    localparam vec_t VEC [10] = '{
        '{1'b0, 1'b0, 5'd3,  8'h55, 16'hA7C3, 16'hC300},   // R4
        '{1'b0, 1'b1, 5'd31, 8'h81, 16'h0000, 16'h0081},   // R3
        '{1'b0, 1'b1, 5'd0,  8'hFF, 16'h0000, 16'h00FF},   // R3
        '{1'b1, 1'b1, 5'd2,  8'h34, 16'h0000, 16'h3400},   // R6 latch from reset
        '{1'b1, 1'b0, 5'd5,  8'h12, 16'hBEEF, 16'hBEEF},   // R5 R6 load
        '{1'b1, 1'b1, 5'd5,  8'h9A, 16'h0000, 16'h9A12},   // R6
        '{1'b0, 1'b0, 5'd7,  8'h77, 16'h0011, 16'h1100},   // R4 R7
        '{1'b1, 1'b1, 5'd7,  8'h56, 16'h0000, 16'h5612},   // R7 latch kept
        '{1'b1, 1'b0, 5'd1,  8'h00, 16'h1234, 16'h1234},   // R5
        '{1'b1, 1'b1, 5'd1,  8'hFF, 16'h0000, 16'hFF00}    // R6
    };

    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            tests++; fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        int pr, pw;
        repeat (3) @(negedge clk);
        #4;
        // R10 reset state
        check(isa_ior_n && isa_iow_n, "R10 strobes high in reset", {isa_ior_n, isa_iow_n}, 3);
        check(!host_ack && !host_data_oe, "R10 ack/oe low in reset", {host_ack, host_data_oe}, 0);
        rst_n = 1'b1;

        foreach (VEC[k]) begin
            pr = ior_pulses; pw = iow_pulses;
            access(VEC[k].wide, VEC[k].win, VEC[k].rg, VEC[k].bt, VEC[k].din);
            check(got_ack, "R8 access acknowledged", got_ack, 1);
            check(snap_addr == (10'h300 + 10'(VEC[k].rg)), "R1 isa address", snap_addr, 10'h300 + 10'(VEC[k].rg));
            check(last_len == STROBE_CYC, "R8 strobe length", last_len, STROBE_CYC);
            if (VEC[k].win) begin
                check(iow_pulses == pw + 1 && ior_pulses == pr, "R2 one write strobe", iow_pulses - pw, 1);
                check(snap_dout == VEC[k].exp, "R3/R6 write data", snap_dout, VEC[k].exp);
                check(!got_oe, "R11 no drive on write", got_oe, 0);
            end else begin
                check(ior_pulses == pr + 1 && iow_pulses == pw, "R2 one read strobe", ior_pulses - pr, 1);
                check(got_data == VEC[k].exp, "R4/R5 read data", got_data, VEC[k].exp);
                check(got_oe, "R11 drive on read", got_oe, 1);
            end
        end

        // R12: keep select high after ack, no further strobe
        @(negedge clk);
        mode_wide = 0; host_addr = mk(1'b0, 5'd4, 8'h00); host_cs = 1'b1;
        pr = ior_pulses;
        repeat (15) @(negedge clk);
        #4;
        check(ior_pulses == pr + 1, "R12 single access per select", ior_pulses - pr, 1);
        check(!host_ack, "R12 ack is one pulse", host_ack, 0);
        host_cs = 1'b0;
        @(negedge clk);

        // R9: abort mid-strobe
        @(negedge clk);
        mode_wide = 0; host_addr = mk(1'b1, 5'd9, 8'h3C); host_cs = 1'b1;
        pw = iow_pulses;
        for (int i = 0; i < 10 && isa_iow_n; i++) begin @(negedge clk); #1; end
        check(!isa_iow_n, "R9 write strobe started", isa_iow_n, 0);
        host_cs = 1'b0;
        #1;
        check(isa_iow_n, "R9 strobe released with select", isa_iow_n, 1);
        got_ack = 0;
        for (int i = 0; i < 6; i++) begin @(negedge clk); #4; if (host_ack) got_ack = 1; end
        check(!got_ack, "R9 no ack after abort", got_ack, 0);

        // R10: reset clears latch
        access(1'b1, 1'b0, 5'd2, 8'hC5, 16'h0000);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        access(1'b1, 1'b1, 5'd2, 8'h11, 16'h0000);
        check(snap_dout == 16'h1100, "R10 latch cleared by reset", snap_dout, 16'h1100);

        // R7: byte-mode read between latch load and wide write
        access(1'b1, 1'b0, 5'd6, 8'hA5, 16'h0000);
        access(1'b0, 1'b0, 5'd6, 8'h5A, 16'h00FF);
        check(got_data == 16'hFF00, "R4 byte read data", got_data, 16'hFF00);
        access(1'b1, 1'b1, 5'd6, 8'h01, 16'h0000);
        check(snap_dout == 16'h01A5, "R7 latch unchanged by byte read", snap_dout, 16'h01A5);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule